// File: doc/BRIEF.md
# Long-Word Access Splitter

This block sits between a processor core and a memory bus that moves one 16-bit word per transfer. The core hands it a single request: a read, a write, a stack push or a stack pop, of byte, word or long size. The block turns that request into one or two word transfers on the memory side, assembles or splits the 32-bit value, extends narrow read results, and pulses a ready signal back to the core when the whole operation is finished.

Long accesses come in two orderings. A normal access moves the upper half at the given address first and the lower half at the address plus two next. A decrementing access, and every long push, moves the lower half first. The block owns the stack pointer used by push and pop. It commits the new pointer value only when the last transfer of the sequence is acknowledged, so a sequence cancelled part-way leaves the pointer as it was.

The core sets the request fields and raises the valid signal. It holds them until ready. Memory transfers use a request/acknowledge pair. The address and write data stay fixed until the acknowledge arrives.

Top module: `lws_top`

## Requirements
- R1: A normal long read (op=0, size=2, dec=0) reads the upper half at A, then the lower half at A+2, and returns {upper, lower}. A normal long write (op=1) writes req_wdata[31:16] at A, then req_wdata[15:0] at A+2.
- R2: A decrementing long access (dec=1, op 0 or 1) moves the lower half at A+2 first, then the upper half at A. A read still returns {upper, lower}.
- R3: A long push (op=2, size 2 or 3) writes req_wdata[15:0] at SP-2, then req_wdata[31:16] at SP-4. SP becomes SP-4.
- R4: A long pop (op=3, size 2 or 3) reads the upper half at SP, then the lower half at SP+2, returns {upper, lower}, and SP becomes SP+4.
- R5: A push or pop of size 0 or 1 is one word transfer. A push writes req_wdata[15:0] at SP-2 and SP becomes SP-2. A pop reads at SP, returns the word extended as in R7, and SP becomes SP+2.
- R6: A byte read or write (size=0, op 0 or 1) is one transfer with mem_byte=1, the byte carried in bits [7:0]. A read returns the byte zero-extended when req_sext=0, or sign-extended from bit 7 when req_sext=1.
- R7: A word read (size=1) is one transfer with mem_byte=0. It returns the word zero-extended when req_sext=0, or sign-extended from bit 15 when req_sext=1.
- R8: While mem_req is high and mem_ack is low, mem_req, mem_addr and mem_wdata hold their values. The second transfer of a long access starts only after the first is acknowledged.
- R9: req_ready is high for exactly one cycle, the cycle after the edge on which the final transfer is acknowledged. req_rdata and sp_out hold the results in that cycle.
- R10: A request is accepted only when the block is idle. Changes to the request inputs while a sequence is in progress have no effect on it. With req_valid low, no transfer starts.
- R11: req_abort high during a sequence drops mem_req on the next edge, produces no ready pulse, and leaves SP unchanged.
- R12: After reset, mem_req and req_ready are low and sp_out equals SP_INIT (default 16'h0100).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request pending |
| req_op | input | 2 | 0 read, 1 write, 2 push, 3 pop |
| req_size | input | 2 | 0 byte, 1 word, 2 or 3 long |
| req_dec | input | 1 | Lower-half-first ordering for long read/write |
| req_sext | input | 1 | Sign-extend narrow read results |
| req_addr | input | AW | Byte address for read/write |
| req_wdata | input | 2*DW | Write or push data |
| req_abort | input | 1 | Cancel the sequence in progress |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 2*DW | Read or pop result |
| sp_out | output | AW | Current stack pointer |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | Transfer is a write |
| mem_byte | output | 1 | Byte transfer on bits [7:0] |
| mem_addr | output | AW | Transfer byte address |
| mem_wdata | output | DW | Transfer write data |
| mem_rdata | input | DW | Transfer read data |
| mem_ack | input | 1 | Transfer acknowledge |

## Verification
The main sequencing is tried with two memory timings: zero-wait acknowledges and three wait cycles per transfer. The first exposes phase-advance and ready-timing slips, and the second exposes an address or data that moves before its acknowledge. Each long pattern is written and then read back in both orderings, and the bench logs the address of every acknowledged transfer, so a swapped half order is caught even when the assembled value would still match. The pushes and pops mix long, word and byte-size stack operations, so pointer arithmetic and result extension are checked together. Byte and word reads with values whose sign bit is set tell zero extension from sign extension. Directed runs then change the request while a sequence is in progress and cancel a push after its first half.

// File: rtl/lws_pkg.sv
package lws_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_PUSH  = 2'd2,
    OP_POP   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } st_e;

  typedef enum logic [2:0] {
    FMT_LONG = 3'd0,
    FMT_W_ZX = 3'd1,
    FMT_W_SX = 3'd2,
    FMT_B_ZX = 3'd3,
    FMT_B_SX = 3'd4
  } fmt_e;
endpackage

// File: rtl/lws_plan.sv
module lws_plan
  import lws_pkg::*;
#(
  parameter int AW   = 16,
  parameter int STEP = 2
) (
  input  logic [1:0]    op,
  input  logic [1:0]    size,
  input  logic          dec,
  input  logic          sext,
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] sp,
  output logic          two,
  output logic          lo_first,
  output logic          we,
  output logic          byte_sel,
  output logic          stack,
  output fmt_e          fmt,
  output logic [AW-1:0] base,
  output logic [AW-1:0] sp_next
);
  localparam logic [AW-1:0] SPAN_W = AW'(STEP);
  localparam logic [AW-1:0] SPAN_L = AW'(2 * STEP);

  op_e opc;
  logic [AW-1:0] span;

  assign opc = op_e'(op);

  always_comb begin
    two      = size[1];
    stack    = op[1];
    we       = (opc == OP_WRITE) || (opc == OP_PUSH);
    byte_sel = !stack && (size == 2'd0);
    lo_first = two && ((!stack && dec) || (opc == OP_PUSH));
    span     = two ? SPAN_L : SPAN_W;
    if (two)           fmt = FMT_LONG;
    else if (byte_sel) fmt = sext ? FMT_B_SX : FMT_B_ZX;
    else               fmt = sext ? FMT_W_SX : FMT_W_ZX;
    base    = addr;
    sp_next = sp;
    case (opc)
      OP_PUSH: begin
        base    = sp - span;
        sp_next = sp - span;
      end
      OP_POP: begin
        base    = sp;
        sp_next = sp + span;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/lws_seq.sv
module lws_seq
  import lws_pkg::*;
#(
  parameter int AW   = 16,
  parameter int DW   = 16,
  parameter int STEP = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic            req_abort,
  input  logic [2*DW-1:0] req_wdata,
  input  logic            p_two,
  input  logic            p_lof,
  input  logic            p_we,
  input  logic            p_byte,
  input  logic            p_stack,
  input  fmt_e            p_fmt,
  input  logic [AW-1:0]   p_base,
  input  logic [AW-1:0]   p_spn,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_byte,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  output logic            ready,
  output logic            fin,
  output fmt_e            fmt_q,
  output logic [DW-1:0]   hi_nx,
  output logic [DW-1:0]   lo_nx,
  output logic            sp_ld,
  output logic [AW-1:0]   sp_val
);
  localparam int LW = 2 * DW;
  localparam logic [AW-1:0] OFS = AW'(STEP);

  st_e            st;
  logic           ph;
  logic           two_q;
  logic           lof_q;
  logic           stk_q;
  logic [AW-1:0]  base_q;
  logic [AW-1:0]  spn_q;
  logic [LW-1:0]  wd_q;
  logic [DW-1:0]  hi_q;
  logic [DW-1:0]  lo_q;

  logic           cur_lo;
  logic           accept;
  logic           take;
  logic           last;
  logic           lo0;
  logic [AW-1:0]  addr0;
  logic [DW-1:0]  data0;
  logic [AW-1:0]  addr1;
  logic [DW-1:0]  data1;

  always_comb begin
    cur_lo = !two_q || (lof_q ^ ph);
    accept = (st == ST_IDLE) && req_valid;
    take   = (st == ST_XFER) && mem_ack && !req_abort;
    last   = !two_q || ph;
    fin    = take && last;
    hi_nx  = (take && !cur_lo) ? mem_rdata : hi_q;
    lo_nx  = (take && cur_lo) ? mem_rdata : lo_q;
    lo0    = !p_two || p_lof;
    addr0  = p_base + ((p_two && p_lof) ? OFS : '0);
    data0  = lo0 ? req_wdata[DW-1:0] : req_wdata[LW-1:DW];
    addr1  = base_q + (lof_q ? '0 : OFS);
    data1  = lof_q ? wd_q[LW-1:DW] : wd_q[DW-1:0];
    sp_ld  = fin && stk_q;
    sp_val = spn_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      ph        <= 1'b0;
      two_q     <= 1'b0;
      lof_q     <= 1'b0;
      stk_q     <= 1'b0;
      fmt_q     <= FMT_LONG;
      base_q    <= '0;
      spn_q     <= '0;
      wd_q      <= '0;
      hi_q      <= '0;
      lo_q      <= '0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_byte  <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      ready     <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st        <= ST_XFER;
            ph        <= 1'b0;
            two_q     <= p_two;
            lof_q     <= p_lof;
            stk_q     <= p_stack;
            fmt_q     <= p_fmt;
            base_q    <= p_base;
            spn_q     <= p_spn;
            wd_q      <= req_wdata;
            mem_req   <= 1'b1;
            mem_we    <= p_we;
            mem_byte  <= p_byte;
            mem_addr  <= addr0;
            mem_wdata <= data0;
          end
        end
        ST_XFER: begin
          if (req_abort) begin
            st      <= ST_IDLE;
            mem_req <= 1'b0;
          end else if (mem_ack) begin
            if (cur_lo) lo_q <= mem_rdata;
            else        hi_q <= mem_rdata;
            if (last) begin
              st      <= ST_DONE;
              mem_req <= 1'b0;
              ready   <= 1'b1;
            end else begin
              ph        <= 1'b1;
              mem_addr  <= addr1;
              mem_wdata <= data1;
            end
          end
        end
        default: begin
          ready <= 1'b0;
          st    <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/lws_ext.sv
module lws_ext
  import lws_pkg::*;
#(
  parameter int DW = 16
) (
  input  fmt_e            fmt,
  input  logic [DW-1:0]   hi,
  input  logic [DW-1:0]   lo,
  output logic [2*DW-1:0] val
);
  localparam int LW = 2 * DW;
  localparam int BW = DW / 2;

  always_comb begin
    case (fmt)
      FMT_W_ZX: val = {{DW{1'b0}}, lo};
      FMT_W_SX: val = {{DW{lo[DW-1]}}, lo};
      FMT_B_ZX: val = {{(LW-BW){1'b0}}, lo[BW-1:0]};
      FMT_B_SX: val = {{(LW-BW){lo[BW-1]}}, lo[BW-1:0]};
      default:  val = {hi, lo};
    endcase
  end
endmodule

// File: rtl/lws_spreg.sv
module lws_spreg #(
  parameter int AW = 16,
  parameter logic [AW-1:0] SP_INIT = 16'h0100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld,
  input  logic [AW-1:0] val,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk) begin
    if (rst)     sp <= SP_INIT;
    else if (ld) sp <= val;
  end
endmodule

// File: rtl/lws_top.sv
module lws_top
  import lws_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter logic [AW-1:0] SP_INIT = 16'h0100
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            req_valid,
  input  logic [1:0]      req_op,
  input  logic [1:0]      req_size,
  input  logic            req_dec,
  input  logic            req_sext,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*DW-1:0] req_wdata,
  input  logic            req_abort,
  output logic            req_ready,
  output logic [2*DW-1:0] req_rdata,
  output logic [AW-1:0]   sp_out,
  output logic            mem_req,
  output logic            mem_we,
  output logic            mem_byte,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_ack
);
  localparam int STEP = DW / 8;
  localparam int LW   = 2 * DW;

  logic          p_two, p_lof, p_we, p_byte, p_stack;
  fmt_e          p_fmt;
  logic [AW-1:0] p_base, p_spn;
  logic          fin, sp_ld;
  fmt_e          fmt_q;
  logic [DW-1:0] hi_nx, lo_nx;
  logic [AW-1:0] sp_val;
  logic [LW-1:0] ext_val;
  logic [LW-1:0] rdata_q;

  lws_plan #(.AW(AW), .STEP(STEP)) u_plan (
    .op(req_op), .size(req_size), .dec(req_dec), .sext(req_sext),
    .addr(req_addr), .sp(sp_out),
    .two(p_two), .lo_first(p_lof), .we(p_we), .byte_sel(p_byte),
    .stack(p_stack), .fmt(p_fmt), .base(p_base), .sp_next(p_spn)
  );

  lws_seq #(.AW(AW), .DW(DW), .STEP(STEP)) u_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_abort(req_abort),
    .req_wdata(req_wdata),
    .p_two(p_two), .p_lof(p_lof), .p_we(p_we), .p_byte(p_byte),
    .p_stack(p_stack), .p_fmt(p_fmt), .p_base(p_base), .p_spn(p_spn),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ready(req_ready), .fin(fin), .fmt_q(fmt_q),
    .hi_nx(hi_nx), .lo_nx(lo_nx), .sp_ld(sp_ld), .sp_val(sp_val)
  );

  lws_ext #(.DW(DW)) u_ext (
    .fmt(fmt_q), .hi(hi_nx), .lo(lo_nx), .val(ext_val)
  );

  lws_spreg #(.AW(AW), .SP_INIT(SP_INIT)) u_sp (
    .clk(clk), .rst(rst), .ld(sp_ld), .val(sp_val), .sp(sp_out)
  );

  always_ff @(posedge clk) begin
    if (rst)      rdata_q <= '0;
    else if (fin) rdata_q <= ext_val;
  end

  assign req_rdata = rdata_q;
endmodule

// File: rtl/lws_chk.sv
module lws_chk #(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          req_valid,
  input logic          req_abort,
  input logic          req_ready,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic [AW-1:0] sp_out
);
  // R8
  hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack && !req_abort) |=> (mem_req && $stable(mem_addr) && $stable(mem_wdata)));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |=> !req_ready);

  // R9
  ready_after_ack_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(req_ready) |-> $past(mem_req && mem_ack));

  // R9
  ready_bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req);

  // R10
  start_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> $past(req_valid));

  // R11
  abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && req_abort) |=> (!mem_req && !req_ready));

  // R11
  sp_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp_out) |-> req_ready);
endmodule

bind lws_top lws_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_abort(req_abort),
  .req_ready(req_ready), .mem_req(mem_req), .mem_ack(mem_ack),
  .mem_addr(mem_addr), .mem_wdata(mem_wdata), .sp_out(sp_out)
);

// File: tb/tb_lws_top.sv
module tb_lws_top;
  typedef struct packed {
    logic [1:0]  op;
    logic [1:0]  sz;
    logic        dec;
    logic        sx;
    logic [15:0] ad;
    logic [31:0] wd;
    logic        chk;
    logic [31:0] rd;
    logic [15:0] sp;
    logic [1:0]  n;
    logic [15:0] a0;
    logic [15:0] a1;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TBL [NV] = '{
    '{2'd1, 2'd2, 1'b0, 1'b0, 16'h0010, 32'h81234567, 1'b0, 32'h0,        16'h0100, 2'd2, 16'h0010, 16'h0012},
    '{2'd0, 2'd2, 1'b0, 1'b0, 16'h0010, 32'h0,        1'b1, 32'h81234567, 16'h0100, 2'd2, 16'h0010, 16'h0012},
    '{2'd1, 2'd2, 1'b1, 1'b0, 16'h0020, 32'hCAFEF00D, 1'b0, 32'h0,        16'h0100, 2'd2, 16'h0022, 16'h0020},
    '{2'd0, 2'd2, 1'b1, 1'b0, 16'h0020, 32'h0,        1'b1, 32'hCAFEF00D, 16'h0100, 2'd2, 16'h0022, 16'h0020},
    '{2'd0, 2'd1, 1'b0, 1'b0, 16'h0010, 32'h0,        1'b1, 32'h00008123, 16'h0100, 2'd1, 16'h0010, 16'h0000},
    '{2'd0, 2'd1, 1'b0, 1'b1, 16'h0010, 32'h0,        1'b1, 32'hFFFF8123, 16'h0100, 2'd1, 16'h0010, 16'h0000},
    '{2'd0, 2'd1, 1'b0, 1'b1, 16'h0012, 32'h0,        1'b1, 32'h00004567, 16'h0100, 2'd1, 16'h0012, 16'h0000},
    '{2'd1, 2'd0, 1'b0, 1'b0, 16'h0031, 32'h000000F0, 1'b0, 32'h0,        16'h0100, 2'd1, 16'h0031, 16'h0000},
    '{2'd0, 2'd0, 1'b0, 1'b0, 16'h0031, 32'h0,        1'b1, 32'h000000F0, 16'h0100, 2'd1, 16'h0031, 16'h0000},
    '{2'd0, 2'd0, 1'b0, 1'b1, 16'h0031, 32'h0,        1'b1, 32'hFFFFFFF0, 16'h0100, 2'd1, 16'h0031, 16'h0000},
    '{2'd1, 2'd0, 1'b0, 1'b0, 16'h0030, 32'h0000007E, 1'b0, 32'h0,        16'h0100, 2'd1, 16'h0030, 16'h0000},
    '{2'd0, 2'd0, 1'b0, 1'b1, 16'h0030, 32'h0,        1'b1, 32'h0000007E, 16'h0100, 2'd1, 16'h0030, 16'h0000},
    '{2'd0, 2'd1, 1'b0, 1'b0, 16'h0030, 32'h0,        1'b1, 32'h00007EF0, 16'h0100, 2'd1, 16'h0030, 16'h0000},
    '{2'd2, 2'd2, 1'b0, 1'b0, 16'h0000, 32'h11223344, 1'b0, 32'h0,        16'h00FC, 2'd2, 16'h00FE, 16'h00FC},
    '{2'd2, 2'd1, 1'b0, 1'b0, 16'h0000, 32'h0000BEEF, 1'b0, 32'h0,        16'h00FA, 2'd1, 16'h00FA, 16'h0000},
    '{2'd2, 2'd0, 1'b0, 1'b0, 16'h0000, 32'h00005A5A, 1'b0, 32'h0,        16'h00F8, 2'd1, 16'h00F8, 16'h0000},
    '{2'd3, 2'd0, 1'b0, 1'b0, 16'h0000, 32'h0,        1'b1, 32'h00005A5A, 16'h00FA, 2'd1, 16'h00F8, 16'h0000},
    '{2'd3, 2'd1, 1'b0, 1'b1, 16'h0000, 32'h0,        1'b1, 32'hFFFFBEEF, 16'h00FC, 2'd1, 16'h00FA, 16'h0000},
    '{2'd3, 2'd3, 1'b0, 1'b0, 16'h0000, 32'h0,        1'b1, 32'h11223344, 16'h0100, 2'd2, 16'h00FC, 16'h00FE}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [1:0]  req_size = 2'd0;
  logic        req_dec = 1'b0;
  logic        req_sext = 1'b0;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_abort = 1'b0;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic [15:0] sp_out;
  logic        mem_req, mem_we, mem_byte;
  logic [15:0] mem_addr, mem_wdata;
  logic [15:0] mem_rdata;
  logic        mem_ack;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int last_ack = 0;
  int nlog = 0;
  int wait_n = 0;
  int wcnt;
  logic [15:0] log_addr [4];
  logic [15:0] mem [256];

  always #10 clk = ~clk;

  lws_top dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_size(req_size), .req_dec(req_dec), .req_sext(req_sext),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_abort(req_abort),
    .req_ready(req_ready), .req_rdata(req_rdata), .sp_out(sp_out),
    .mem_req(mem_req), .mem_we(mem_we), .mem_byte(mem_byte),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ack(mem_ack)
  );

  // memory model: word array, byte lane 0 is the upper byte
  always_comb begin
    if (mem_byte) mem_rdata = {8'h00, mem_addr[0] ? mem[mem_addr[8:1]][7:0] : mem[mem_addr[8:1]][15:8]};
    else          mem_rdata = mem[mem_addr[8:1]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end else if (mem_req && !mem_ack) begin
      if (wcnt >= wait_n) begin
        mem_ack <= 1'b1;
        wcnt    <= 0;
      end else begin
        wcnt <= wcnt + 1;
      end
    end else begin
      mem_ack <= 1'b0;
      wcnt    <= 0;
    end
  end

  always @(posedge clk) begin
    if (!rst && mem_req && mem_ack) begin
      if (mem_we) begin
        if (!mem_byte) mem[mem_addr[8:1]] <= mem_wdata;
        else if (mem_addr[0]) mem[mem_addr[8:1]][7:0] <= mem_wdata[7:0];
        else mem[mem_addr[8:1]][15:8] <= mem_wdata[7:0];
      end
      if (nlog < 4) log_addr[nlog] = mem_addr;
      nlog = nlog + 1;
      last_ack = cyc;
    end
    cyc = cyc + 1;
    if (cyc > 100000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      fails = fails + 1;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic start_op(input logic [1:0] op, input logic [1:0] sz, input logic dec,
                          input logic sx, input logic [15:0] ad, input logic [31:0] wd);
    @(negedge clk);
    req_op = op; req_size = sz; req_dec = dec; req_sext = sx;
    req_addr = ad; req_wdata = wd; req_valid = 1'b1;
    nlog = 0;
  endtask

  task automatic wait_done(output logic ok);
    ok = 1'b0;
    for (int n = 0; n < 200; n++) begin
      @(negedge clk);
      if (req_ready) begin
        ok = 1'b1;
        break;
      end
    end
    req_valid = 1'b0;
  endtask

  task automatic run_table(input string pass);
    logic ok;
    for (int i = 0; i < NV; i++) begin
      start_op(TBL[i].op, TBL[i].sz, TBL[i].dec, TBL[i].sx, TBL[i].ad, TBL[i].wd);
      wait_done(ok);
      chk({pass, " R9 ready reached"}, 32'(ok), 32'd1);
      // R1 R2 R3 R4 R5 R6 R7: transfer count, order, result, pointer
      chk({pass, " R1/R2/R5 transfer count"}, 32'(nlog), 32'(TBL[i].n));
      chk({pass, " R1/R2/R3/R6 first address"}, 32'(log_addr[0]), 32'(TBL[i].a0));
      if (TBL[i].n == 2'd2) chk({pass, " R2/R4 second address"}, 32'(log_addr[1]), 32'(TBL[i].a1));
      if (TBL[i].chk) chk({pass, " R4/R6/R7 read result"}, req_rdata, TBL[i].rd);
      chk({pass, " R3/R5 stack pointer"}, 32'(sp_out), 32'(TBL[i].sp));
      chk({pass, " R9 ready one cycle after last ack"}, 32'(cyc - last_ack), 32'd1);
      @(negedge clk);
      chk({pass, " R9 ready single cycle"}, 32'(req_ready), 32'd0);
    end
  endtask

  initial begin
    logic ok;
    logic seen;
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 mem_req in reset", 32'(mem_req), 32'd0);
    chk("R12 ready in reset", 32'(req_ready), 32'd0);
    chk("R12 sp init", 32'(sp_out), 32'h0100);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 sp after reset", 32'(sp_out), 32'h0100);

    wait_n = 0;
    run_table("nowait");
    wait_n = 3;
    run_table("wait3");

    // R10 request inputs changed mid-sequence have no effect; idle with valid low stays quiet
    start_op(2'd0, 2'd2, 1'b0, 1'b0, 16'h0010, 32'h0);
    for (int n = 0; n < 50 && nlog < 1; n++) @(negedge clk);
    req_op = 2'd1; req_addr = 16'h0020; req_wdata = 32'h0; req_dec = 1'b1;
    wait_done(ok);
    chk("R10 sequence completes", 32'(ok), 32'd1);
    chk("R10 second address kept", 32'(log_addr[1]), 32'h0012);
    chk("R10 result kept", req_rdata, 32'h81234567);
    for (int n = 0; n < 4; n++) begin
      @(negedge clk);
      chk("R10 no transfer while valid low", 32'(mem_req), 32'd0);
    end
    start_op(2'd0, 2'd2, 1'b1, 1'b0, 16'h0020, 32'h0);
    wait_done(ok);
    chk("R10 target untouched", req_rdata, 32'hCAFEF00D);

    // R11 abort a long push after its first half
    start_op(2'd2, 2'd2, 1'b0, 1'b0, 16'h0000, 32'h99887766);
    for (int n = 0; n < 50 && nlog < 1; n++) @(negedge clk);
    req_abort = 1'b1;
    @(negedge clk);
    req_abort = 1'b0;
    req_valid = 1'b0;
    chk("R11 mem_req dropped", 32'(mem_req), 32'd0);
    seen = 1'b0;
    for (int n = 0; n < 6; n++) begin
      @(negedge clk);
      if (req_ready || mem_req) seen = 1'b1;
    end
    chk("R11 no ready or transfer after abort", 32'(seen), 32'd0);
    chk("R11 sp unchanged", 32'(sp_out), 32'h0100);
    start_op(2'd0, 2'd2, 1'b0, 1'b0, 16'h0010, 32'h0);
    wait_done(ok);
    chk("R11 recovery read", req_rdata, 32'h81234567);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule